// File: doc/BRIEF.md
# I2C SCL Phase Timing Generator

This block paces the clock line of an I2C master. A two-level divider sets the length of each SCL half-period. An inner counter turns a programmable number of source clocks (the step count) into one step tick. An outer counter turns a programmable number of step ticks (the sample count) into one SCL half-period. A half-period therefore lasts step × sample source clocks, and the SCL rate is the source clock divided by 2 × sample × step. The block also gives a strobe for sampling SDA in the middle of the high half and a strobe for driving SDA in the low half, at a programmable delay.

Two 16-bit configuration words feed the block. The first serves standard and fast rates (up to 400 kHz). The second serves high-speed rates (above 400 kHz, up to 3.4 MHz) and has a narrower step range. Each field holds its count minus one. The transaction sequencer raises the enable input to run the generator. The block captures the configuration at the cycle that enable rises. Later changes to the configuration words wait for the next enable. While enable is low, both counters rest at zero and SCL stays released high.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset, and before enable is first raised, `scl_o` is 1 and `step_tick_o`, `fall_o`, `rise_o`, `sample_o` and `drive_o` are all 0.
- R2: In standard/fast mode the step count is `std_cfg_i[5:0]`+1 (1 to 64) and the sample count is `std_cfg_i[10:8]`+1 (1 to 8). Each SCL half-period lasts step × sample source clocks.
- R3: High-speed mode is selected when `hs_cfg_i[1:0]` is 2'b11. The step count is then `hs_cfg_i[10:8]`+1 and the sample count is `hs_cfg_i[14:12]`+1, `std_cfg_i` has no effect on the timing, and `hs_mode_o` reads 1.
- R4: When `hs_cfg_i[1:0]` is anything other than 2'b11, the block uses the standard/fast fields and `hs_mode_o` reads 0.
- R5: SCL starts high when enable is captured. The halves alternate high and low. `fall_o` pulses on the cycle that SCL goes from 1 to 0, and `rise_o` pulses on the cycle that SCL goes from 0 to 1.
- R6: While enabled, `step_tick_o` pulses once every step-count source clocks. The first pulse comes step-count cycles after the capturing edge, and every SCL change coincides with a step tick.
- R7: In each high half, `sample_o` pulses once, on step tick index floor(sample/2) of that half. Ticks are counted from 0.
- R8: In each low half, `drive_o` pulses once, on step tick index min(D, sample−1), where D is `std_cfg_i[14:12]` in standard/fast mode and 0 in high-speed mode.
- R9: Changes to `std_cfg_i` or `hs_cfg_i` while enable stays high do not change the running timing. They take effect at the next enable.
- R10: One cycle after enable is seen low, `scl_o` is 1 and every pulse output is 0. A later enable restarts from the beginning of a high half.
- R11: The extremes of the range work: step 64 × sample 8 gives 512-clock halves, and step 1 × sample 1 toggles SCL on every clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Source clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run request from the transaction sequencer |
| std_cfg_i | input | 16 | Standard/fast timing word: step−1 [5:0], sample−1 [10:8], drive delay [14:12] |
| hs_cfg_i | input | 16 | High-speed word: mode key [1:0]=2'b11, step−1 [10:8], sample−1 [14:12] |
| scl_o | output | 1 | SCL level, 1 = released |
| step_tick_o | output | 1 | Pulse at the end of every step |
| fall_o | output | 1 | Pulse where a high half ends and SCL goes low |
| rise_o | output | 1 | Pulse where a low half ends and SCL goes high |
| sample_o | output | 1 | SDA sample strobe within the high half |
| drive_o | output | 1 | SDA drive strobe within the low half |
| hs_mode_o | output | 1 | The captured configuration is high-speed |

## Verification
The bound assertions check, on every cycle, the properties that hold regardless of the configuration:
- SCL is released and the pulses are quiet after enable drops.
- The fall and rise pulses never coincide, and each matches the SCL level it produces.
- Every SCL change falls on a step tick.
- The sample and drive strobes stay in their proper halves.
- The inner counter never passes its limit.
- The captured limit stays constant during a run.

Only the bench scenarios can show the exact cycle positions, because those depend on the programmed counts: the half-period lengths, the strobe indices, the delay clamp, the mode-key decoding, and the deferral of configuration changes.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;

    parameter int CFG_W        = 16;
    parameter int STEP_W       = 6;
    parameter int SAMP_W       = 3;
    parameter int DLY_W        = 3;
    parameter int HS_STEP_W    = 3;
    parameter int HS_KEY_W     = 2;

    parameter int STD_STEP_LSB = 0;
    parameter int STD_SAMP_LSB = 8;
    parameter int STD_DLY_LSB  = 12;
    parameter int HS_KEY_LSB   = 0;
    parameter int HS_STEP_LSB  = 8;
    parameter int HS_SAMP_LSB  = 12;

    parameter logic [HS_KEY_W-1:0] HS_KEY = 2'b11;

    typedef struct packed {
        logic              hs;
        logic [STEP_W-1:0] step_lim;
        logic [SAMP_W-1:0] samp_lim;
        logic [SAMP_W-1:0] samp_mid;
        logic [SAMP_W-1:0] drv_idx;
    } scl_cfg_t;

endpackage

// File: rtl/scl_cfg_decode.sv
module scl_cfg_decode
    import scl_timing_pkg::*;
(
    input  logic [CFG_W-1:0] std_word_i,
    input  logic [CFG_W-1:0] hs_word_i,
    output scl_cfg_t         cfg_o
);

    logic              hs_sel;
    logic [SAMP_W-1:0] samp_lim;
    logic [DLY_W-1:0]  dly;
    logic [SAMP_W:0]   samp_cnt_full;

    always_comb begin
        hs_sel = (hs_word_i[HS_KEY_LSB +: HS_KEY_W] == HS_KEY);

        if (hs_sel) begin
            cfg_o.step_lim = STEP_W'(hs_word_i[HS_STEP_LSB +: HS_STEP_W]);
            samp_lim       = hs_word_i[HS_SAMP_LSB +: SAMP_W];
            dly            = '0;
        end else begin
            cfg_o.step_lim = std_word_i[STD_STEP_LSB +: STEP_W];
            samp_lim       = std_word_i[STD_SAMP_LSB +: SAMP_W];
            dly            = std_word_i[STD_DLY_LSB +: DLY_W];
        end

        samp_cnt_full  = {1'b0, samp_lim} + 1'b1;
        cfg_o.hs       = hs_sel;
        cfg_o.samp_lim = samp_lim;
        cfg_o.samp_mid = SAMP_W'(samp_cnt_full >> 1);
        cfg_o.drv_idx  = (SAMP_W'(dly) > samp_lim) ? samp_lim : SAMP_W'(dly);
    end

endmodule

// File: rtl/scl_phase_ctr.sv
module scl_phase_ctr #(
    parameter int W = 4
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         clr_i,
    input  logic         adv_i,
    input  logic [W-1:0] lim_i,
    output logic [W-1:0] cnt_o,
    output logic         wrap_o
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        wrap_o = adv_i && !clr_i && (cnt_q == lim_i);
        cnt_d  = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (adv_i) begin
            cnt_d = wrap_o ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
    import scl_timing_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic [CFG_W-1:0] std_cfg_i,
    input  logic [CFG_W-1:0] hs_cfg_i,
    output logic             scl_o,
    output logic             step_tick_o,
    output logic             fall_o,
    output logic             rise_o,
    output logic             sample_o,
    output logic             drive_o,
    output logic             hs_mode_o
);

    typedef struct packed {
        logic     running;
        logic     scl;
        logic     step_tick;
        logic     fall;
        logic     rise;
        logic     sample;
        logic     drive;
        scl_cfg_t cfg;
    } gen_state_t;

    localparam gen_state_t IDLE_STATE = '{
        running:   1'b0,
        scl:       1'b1,
        step_tick: 1'b0,
        fall:      1'b0,
        rise:      1'b0,
        sample:    1'b0,
        drive:     1'b0,
        cfg:       '0
    };

    gen_state_t        st_d, st_q;
    scl_cfg_t          cfg_new;
    logic              ctr_clr, ctr_adv;
    logic [STEP_W-1:0] step_cnt;
    logic [SAMP_W-1:0] samp_cnt;
    logic              step_wrap, half_wrap;
    logic [STEP_W-1:0] step_lim;

    scl_cfg_decode u_decode (
        .std_word_i (std_cfg_i),
        .hs_word_i  (hs_cfg_i),
        .cfg_o      (cfg_new)
    );

    assign ctr_clr  = !(st_q.running && en_i);
    assign ctr_adv  = st_q.running && en_i;
    assign step_lim = st_q.cfg.step_lim;

    scl_phase_ctr #(.W(STEP_W)) u_step_ctr (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (ctr_clr),
        .adv_i  (ctr_adv),
        .lim_i  (step_lim),
        .cnt_o  (step_cnt),
        .wrap_o (step_wrap)
    );

    scl_phase_ctr #(.W(SAMP_W)) u_samp_ctr (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (ctr_clr),
        .adv_i  (step_wrap),
        .lim_i  (st_q.cfg.samp_lim),
        .cnt_o  (samp_cnt),
        .wrap_o (half_wrap)
    );

    always_comb begin
        st_d           = st_q;
        st_d.step_tick = 1'b0;
        st_d.fall      = 1'b0;
        st_d.rise      = 1'b0;
        st_d.sample    = 1'b0;
        st_d.drive     = 1'b0;

        if (!en_i) begin
            st_d = IDLE_STATE;
            st_d.cfg = st_q.cfg;
        end else if (!st_q.running) begin
            st_d.running = 1'b1;
            st_d.scl     = 1'b1;
            st_d.cfg     = cfg_new;
        end else begin
            st_d.step_tick = step_wrap;
            st_d.fall      = half_wrap && st_q.scl;
            st_d.rise      = half_wrap && !st_q.scl;
            st_d.sample    = step_wrap && st_q.scl
                             && (samp_cnt == st_q.cfg.samp_mid);
            st_d.drive     = step_wrap && !st_q.scl
                             && (samp_cnt == st_q.cfg.drv_idx);
            if (half_wrap) begin
                st_d.scl = !st_q.scl;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= IDLE_STATE;
        end else begin
            st_q <= st_d;
        end
    end

    assign scl_o       = st_q.scl;
    assign step_tick_o = st_q.step_tick;
    assign fall_o      = st_q.fall;
    assign rise_o      = st_q.rise;
    assign sample_o    = st_q.sample;
    assign drive_o     = st_q.drive;
    assign hs_mode_o   = st_q.cfg.hs;

endmodule

// File: rtl/scl_timing_gen_chk.sv
module scl_timing_gen_chk
    import scl_timing_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic              en_i,
    input logic              scl_o,
    input logic              step_tick_o,
    input logic              fall_o,
    input logic              rise_o,
    input logic              sample_o,
    input logic              drive_o,
    input logic              running_i,
    input logic [STEP_W-1:0] step_cnt_i,
    input logic [STEP_W-1:0] step_lim_i
);

    p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> (scl_o && !step_tick_o && !fall_o && !rise_o && !sample_o && !drive_o));

    p_edge_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({fall_o, rise_o}));

    p_fall_level_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fall_o |-> !scl_o);

    p_rise_level_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_o |-> scl_o);

    p_edge_on_tick_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fall_o || rise_o) |-> step_tick_o);

    p_sample_high_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sample_o |-> (step_tick_o && (scl_o || fall_o)));

    p_drive_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        drive_o |-> (step_tick_o && (!scl_o || rise_o)));

    p_step_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        running_i |-> (step_cnt_i <= step_lim_i));

    p_cfg_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (running_i && $past(running_i)) |-> $stable(step_lim_i));

endmodule

bind scl_timing_gen scl_timing_gen_chk u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .scl_o       (scl_o),
    .step_tick_o (step_tick_o),
    .fall_o      (fall_o),
    .rise_o      (rise_o),
    .sample_o    (sample_o),
    .drive_o     (drive_o),
    .running_i   (st_q.running),
    .step_cnt_i  (step_cnt),
    .step_lim_i  (step_lim)
);

// File: tb/tb_scl_timing_gen.sv
module tb_scl_timing_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [15:0] std_cfg = '0;
    logic [15:0] hs_cfg = '0;
    logic        scl, step_tick, fall, rise, sample, drive, hs_mode;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    scl_timing_gen dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .en_i        (en),
        .std_cfg_i   (std_cfg),
        .hs_cfg_i    (hs_cfg),
        .scl_o       (scl),
        .step_tick_o (step_tick),
        .fall_o      (fall),
        .rise_o      (rise),
        .sample_o    (sample),
        .drive_o     (drive),
        .hs_mode_o   (hs_mode)
    );

    task automatic chk(string req, string what, int t, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s t=%0d actual=%0b expected=%0b", req, what, t, act, exp);
        end
    endtask

    task automatic chk_idle(string req, int t);
        chk(req, "scl", t, scl, 1'b1);
        chk(req, "step_tick", t, step_tick, 1'b0);
        chk(req, "fall", t, fall, 1'b0);
        chk(req, "rise", t, rise, 1'b0);
        chk(req, "sample", t, sample, 1'b0);
        chk(req, "drive", t, drive, 1'b0);
    endtask

    // Runs one enable period and compares every cycle with a model built
    // from the requirements. S and N are the step and sample counts, dd is
    // the effective drive index. The inputs change to std2/hs2 at cycle chg_at
    // (0 = never) and the run stops after ncyc cycles.
    task automatic run_case(string req, logic [15:0] s_w, logic [15:0] h_w,
                            int S, int N, int dd, logic exp_hs, int ncyc,
                            int chg_at, logic [15:0] std2, logic [15:0] hs2);
        @(negedge clk);
        std_cfg = s_w;
        hs_cfg  = h_w;
        en      = 1'b1;
        @(negedge clk);
        chk_idle(req, 0);
        chk(req, "hs_mode", 0, hs_mode, exp_hs);
        for (int t = 1; t <= ncyc; t++) begin
            logic e_tick, e_scl, e_fall, e_rise, e_samp, e_drv;
            int k, p, h;
            if (t == chg_at) begin
                std_cfg = std2;
                hs_cfg  = hs2;
            end
            @(negedge clk);
            e_tick = (t % S) == 0;
            k = t / S;
            p = (k - 1) % N;
            h = (k - 1) / N;
            e_scl  = ((t / (S * N)) % 2) == 0;
            e_fall = e_tick && (p == N - 1) && (h % 2 == 0);
            e_rise = e_tick && (p == N - 1) && (h % 2 == 1);
            e_samp = e_tick && (h % 2 == 0) && (p == N / 2);
            e_drv  = e_tick && (h % 2 == 1) && (p == dd);
            chk(req, "scl", t, scl, e_scl);
            chk(req, "step_tick", t, step_tick, e_tick);
            chk(req, "fall", t, fall, e_fall);
            chk(req, "rise", t, rise, e_rise);
            chk(req, "sample", t, sample, e_samp);
            chk(req, "drive", t, drive, e_drv);
            chk(req, "hs_mode", t, hs_mode, exp_hs);
        end
        en = 1'b0;
        @(negedge clk);
        chk_idle({req, "/R10"}, ncyc + 1);
    endtask

    function automatic logic [15:0] std_word(int S, int N, int D);
        return 16'((D << 12) | ((N - 1) << 8) | (S - 1));
    endfunction

    function automatic logic [15:0] hs_word(int S, int N, int key);
        return 16'(((N - 1) << 12) | ((S - 1) << 8) | key);
    endfunction

    task automatic t_reset;
        @(negedge clk);
        chk_idle("R1", 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk_idle("R1", 3);
        chk("R1", "hs_mode", 3, hs_mode, 1'b0);
    endtask

    task automatic t_std_basic;
        // R2 R5 R6 R7 R8: step 4, sample 3, drive delay 1
        run_case("R2", std_word(4, 3, 1), 16'h0, 4, 3, 1, 1'b0, 4*3*4 + 3, 0, '0, '0);
    endtask

    task automatic t_std_clamp;
        // R8: delay 6 beyond sample count 4 clamps to index 3
        run_case("R8", std_word(5, 4, 6), 16'h0, 5, 4, 3, 1'b0, 5*4*4, 0, '0, '0);
    endtask

    task automatic t_hs;
        // R3: high-speed key, std word holds junk that must not matter
        run_case("R3", std_word(9, 2, 5), hs_word(3, 5, 3), 3, 5, 0, 1'b1, 3*5*4, 0, '0, '0);
    endtask

    task automatic t_hs_key_off;
        // R4: key 2'b01 leaves standard mode in force
        run_case("R4", std_word(2, 5, 2), hs_word(3, 5, 1), 2, 5, 2, 1'b0, 2*5*4, 0, '0, '0);
    endtask

    task automatic t_extremes;
        // R11: largest and smallest divider
        run_case("R11", std_word(64, 8, 0), 16'h0, 64, 8, 0, 1'b0, 64*8*2 + 5, 0, '0, '0);
        run_case("R11", std_word(1, 1, 3), 16'h0, 1, 1, 0, 1'b0, 6, 0, '0, '0);
    endtask

    task automatic t_deferred_cfg;
        // R9: change inputs mid-run, old timing continues; stop mid-half (R10)
        run_case("R9", std_word(2, 2, 1), 16'h0, 2, 2, 1, 1'b0, 17, 3,
                 std_word(3, 3, 0), hs_word(2, 2, 3));
        // R9: next enable picks up the new inputs (high-speed, step 2 sample 2)
        run_case("R9", std_word(3, 3, 0), hs_word(2, 2, 3), 2, 2, 0, 1'b1, 16, 0, '0, '0);
    endtask

    initial begin
        t_reset();
        t_std_basic();
        t_std_clamp();
        t_hs();
        t_hs_key_off();
        t_extremes();
        t_deferred_cfg();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule